// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental quadrature encoder into a signed position count. Each legal one-step change of the phase pair moves the count up or down by one. A jump in which both phases change at once is treated as a fault: the count does not move and an error pulse is raised. A polarity input reverses the counting direction.

An index input and a home input can set the count back to a known value. The action they take is chosen by a 3-bit initialization mode. In some modes a qualified index clears the count, and in others it loads a value. One mode waits for the first qualified index after a home event, and another waits for the second. The count can also be cleared when it reaches a compare value, or made to wrap between a lower and an upper bound.

A 2-bit phase-qualifier code decides which phase state lets an index edge count as an event. A counter-mode input can switch the block into a timer, which counts prescaled clock ticks and ignores the phases and the index. All control values are plain input ports. The phase, index and home inputs are synchronized inside the block. The sampling clock must run at least twice as fast as the fastest expected phase edge rate.

Top module: `qenc_poscnt`

## Requirements
- R1: After reset, `position` is 0 and `phase_err` is 0.
- R2: With `cnt_mode[1]`=0 and phase state written {A,B}, the sequence 00→01→11→10→00 adds one per step and the reverse subtracts one. Setting `dir_inv`=1 swaps the two directions.
- R3: A change of both phases in one sampled step leaves `position` unchanged and drives `phase_err` high for exactly one cycle.
- R4: While `en`=0, `position` holds its value. Phase steps made while disabled are not counted later, and the first step after `en` returns moves the count by exactly one.
- R5: An index event is a rising edge of the synchronized index input that occurs while {B,A} equals `idx_match`. So 2'b11 means A=1,B=1; 2'b10 means A=0,B=1; 2'b01 means A=1,B=0. The code 2'b00 never qualifies. In `init_mode` 3'b001, an index event clears `position` to 0.
- R6: In `init_mode` 3'b010, every index event loads `position` from `load_val`.
- R7: A rising edge on `home` arms the block. In `init_mode` 3'b011, the first index event after arming loads `load_val`. In `init_mode` 3'b100, the second index event after arming loads `load_val`. Either load disarms the block. Index events while the block is not armed have no effect.
- R8: In `init_mode` 3'b101, `position` becomes 0 on the cycle after it equals `cmp_val`.
- R9: In `init_mode` 3'b110, an up step from `cmp_val` gives `load_val`, and a down step from `load_val` gives `cmp_val`. All other steps move the count by one.
- R10: With `cnt_mode[1]`=1, `position` adds one every N clock cycles and ignores the phases, the index and `init_mode`. N is 2^`div_sel` for `div_sel` 0 to 6, and 256 for `div_sel`=7.
- R11: In `init_mode` 3'b000 and 3'b111, index events leave `position` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| index_in | input | 1 | Encoder index (asynchronous) |
| home_in | input | 1 | Home reference (asynchronous) |
| init_mode | input | 3 | Initialization mode select |
| idx_match | input | 2 | Phase state {B,A} that qualifies an index edge |
| cnt_mode | input | 2 | Bit 1 set selects timer operation |
| div_sel | input | 3 | Timer prescale select |
| dir_inv | input | 1 | Reverse counting direction |
| load_val | input | 32 | Load value and modulo lower bound |
| cmp_val | input | 32 | Compare value and modulo upper bound |
| position | output | 32 | Signed position count |
| phase_err | output | 1 | One-cycle pulse on an illegal phase jump |

## Verification
The hardest case to reach from the ports is the second-index-after-home load. It only fires when a home edge has armed the block and a qualified index edge has already been seen and absorbed. The stimulus walks the phases into the matching state, pulses index once with no home to show that nothing happens, pulses home, and then pulses index twice. It checks that the first of those two pulses leaves the count alone and that the second one loads it. A sweep over every qualifier code against every phase state, with a distinct load value for each pair, shows exactly which combinations count as index events.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [2:0] {
    IM_NONE     = 3'd0,
    IM_IDX_CLR  = 3'd1,
    IM_IDX_LOAD = 3'd2,
    IM_HOME1    = 3'd3,
    IM_HOME2    = 3'd4,
    IM_CMP_CLR  = 3'd5,
    IM_MODULO   = 3'd6,
    IM_RSVD     = 3'd7
  } init_mode_e;

  // Position of a {A,B} phase state along the increment cycle.
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_pos = 2'd0;
      2'b01:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_in[i];
        s2_q <= s1_q;
      end
    end
    assign d_out[i] = s2_q;
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic up,
  output logic dn,
  output logic err
);
  logic [1:0] prev_q;
  logic [1:0] cur_p, prev_p, diff;

  always_comb begin
    cur_p  = gray_pos({a, b});
    prev_p = gray_pos(prev_q);
    diff   = cur_p - prev_p;
    up     = (diff == 2'd1);
    dn     = (diff == 2'd3);
    err    = (diff == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= {a, b};
  end

  // R3
  step_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up, dn, err}));
endmodule

// File: rtl/qenc_prescale.sv
module qenc_prescale #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam logic [SEL_W-1:0] SEL_MAX = {SEL_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    if (div_sel == SEL_MAX) lim = {CNT_W{1'b1}};
    else                    lim = CNT_W'((1 << div_sel) - 1);
    tick  = run && (cnt_q >= lim);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
  import qenc_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic             home_in,
  input  logic [2:0]       init_mode,
  input  logic [1:0]       idx_match,
  input  logic [1:0]       cnt_mode,
  input  logic [2:0]       div_sel,
  input  logic             dir_inv,
  input  logic [POS_W-1:0] load_val,
  input  logic [POS_W-1:0] cmp_val,
  output logic [POS_W-1:0] position,
  output logic             phase_err
);
  logic [3:0] sync_o;
  logic       s_a, s_b, s_idx, s_home;
  logic       dec_up, dec_dn, dec_err, tick;
  logic       step_up, step_dn, timer_on, idx_ev, home_rise;
  logic       idx_d_q, home_d_q;
  logic       armed_q, armed_d, seen_q, seen_d;
  logic [POS_W-1:0] pos_q, pos_d;
  init_mode_e mode;

  qenc_sync #(.N(4)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({home_in, index_in, phase_b, phase_a}), .d_out(sync_o));
  assign {s_home, s_idx, s_b, s_a} = sync_o;

  qenc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .a(s_a), .b(s_b),
    .up(dec_up), .dn(dec_dn), .err(dec_err));

  assign timer_on = cnt_mode[1];

  qenc_prescale #(.SEL_W(3), .CNT_W(8)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en && timer_on),
    .div_sel(div_sel), .tick(tick));

  always_comb begin
    mode      = init_mode_e'(init_mode);
    step_up   = dir_inv ? dec_dn : dec_up;
    step_dn   = dir_inv ? dec_up : dec_dn;
    idx_ev    = s_idx && !idx_d_q && (idx_match != 2'b00) && ({s_b, s_a} == idx_match);
    home_rise = s_home && !home_d_q;
  end

  always_comb begin
    pos_d   = pos_q;
    armed_d = armed_q;
    seen_d  = seen_q;
    if (en) begin
      if (timer_on) begin
        if (tick) pos_d = pos_q + 1'b1;
      end else begin
        if (home_rise) begin
          armed_d = 1'b1;
          seen_d  = 1'b0;
        end
        case (mode)
          IM_CMP_CLR: begin
            if (pos_q == cmp_val) pos_d = '0;
            else if (step_up)     pos_d = pos_q + 1'b1;
            else if (step_dn)     pos_d = pos_q - 1'b1;
          end
          IM_MODULO: begin
            if (step_up)      pos_d = (pos_q == cmp_val)  ? load_val : pos_q + 1'b1;
            else if (step_dn) pos_d = (pos_q == load_val) ? cmp_val  : pos_q - 1'b1;
          end
          default: begin
            if (step_up)      pos_d = pos_q + 1'b1;
            else if (step_dn) pos_d = pos_q - 1'b1;
          end
        endcase
        if (idx_ev) begin
          case (mode)
            IM_IDX_CLR:  pos_d = '0;
            IM_IDX_LOAD: pos_d = load_val;
            IM_HOME1: if (armed_q) begin
              pos_d   = load_val;
              armed_d = 1'b0;
            end
            IM_HOME2: if (armed_q) begin
              if (seen_q) begin
                pos_d   = load_val;
                armed_d = 1'b0;
                seen_d  = 1'b0;
              end else begin
                seen_d = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      armed_q   <= 1'b0;
      seen_q    <= 1'b0;
      idx_d_q   <= 1'b0;
      home_d_q  <= 1'b0;
      phase_err <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      armed_q   <= armed_d;
      seen_q    <= seen_d;
      idx_d_q   <= s_idx;
      home_d_q  <= s_home;
      phase_err <= dec_err && !timer_on;
    end
  end

  assign position = pos_q;

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(position));

  // R10
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && timer_on && !tick) |=> $stable(position));

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !timer_on && mode == IM_NONE) |=>
      (position == $past(position) || position == $past(position) + 1 ||
       position == $past(position) - 1));

  // R8
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !timer_on && mode == IM_CMP_CLR && pos_q == cmp_val) |=> position == '0);
endmodule

// File: tb/qenc_poscnt_tb.sv
module qenc_poscnt_tb;
  logic        clk = 1'b0;
  logic        rst_n, en, pa, pb, idx, home, dir_inv, perr;
  logic [2:0]  init_mode, div_sel;
  logic [1:0]  idx_match, cnt_mode;
  logic [31:0] load_val, cmp_val, pos;
  int n_chk = 0, n_fail = 0;
  int ph = 0;
  bit done = 0;

  always #10 clk = ~clk;

  qenc_poscnt u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_a(pa), .phase_b(pb),
    .index_in(idx), .home_in(home), .init_mode(init_mode),
    .idx_match(idx_match), .cnt_mode(cnt_mode), .div_sel(div_sel),
    .dir_inv(dir_inv), .load_val(load_val), .cmp_val(cmp_val),
    .position(pos), .phase_err(perr));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ph(input int p);
    ph = p & 3;
    case (ph)
      0: {pa, pb} = 2'b00;
      1: {pa, pb} = 2'b01;
      2: {pa, pb} = 2'b11;
      default: {pa, pb} = 2'b10;
    endcase
  endtask

  task automatic step(input bit fwd);
    set_ph(fwd ? ph + 1 : ph + 3);
    wait_n(5);
  endtask

  task automatic pulse_idx();
    idx = 1'b1; wait_n(4); idx = 1'b0; wait_n(4);
  endtask

  task automatic pulse_home();
    home = 1'b1; wait_n(4); home = 1'b0; wait_n(4);
  endtask

  // Walk to phase index p with forward steps.
  task automatic goto_ph(input int p);
    while (ph != (p & 3)) step(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, exp_v;
    bit saw;
    rst_n = 0; en = 0; pa = 0; pb = 0; idx = 0; home = 0; dir_inv = 0;
    init_mode = 3'd0; div_sel = 3'd0; idx_match = 2'b00; cnt_mode = 2'b00;
    load_val = 0; cmp_val = 0;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    chk(pos, 0, "R1 position after reset");
    chk({31'd0, perr}, 0, "R1 phase_err after reset");

    en = 1;
    for (int i = 0; i < 10; i++) step(1'b1);
    chk(pos, 10, "R2 ten up steps");
    for (int i = 0; i < 3; i++) step(1'b0);
    chk(pos, 7, "R2 three down steps");
    dir_inv = 1;
    step(1'b1); step(1'b1);
    chk(pos, 5, "R2 inverted direction");
    dir_inv = 0;

    // R3: both phases change at once
    saw = 0;
    set_ph(ph + 2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (perr) saw = 1;
    end
    chk(pos, 5, "R3 jump not counted");
    chk({31'd0, saw}, 1, "R3 phase_err pulse");
    chk({31'd0, perr}, 0, "R3 phase_err cleared");

    // R4
    en = 0;
    for (int i = 0; i < 4; i++) step(1'b1);
    chk(pos, 5, "R4 hold while disabled");
    en = 1;
    wait_n(3);
    step(1'b1);
    chk(pos, 6, "R4 single step after enable");

    // R5/R6 sweep: qualifier code vs phase state, mode 010
    init_mode = 3'd2;
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        idx_match = m[1:0];
        goto_ph(s);
        base = pos;
        load_val = 32'd5000 + 32'(m * 4 + s);
        pulse_idx();
        // {B,A} of this phase state
        exp_v = (m != 0 && {pb, pa} == m[1:0]) ? load_val : base;
        chk(pos, exp_v, $sformatf("R5 R6 match=%0d state=%0d", m, s));
      end
    end

    // R5 clear in mode 001, A=1,B=1 (state 2)
    init_mode = 3'd1; idx_match = 2'b11;
    goto_ph(2);
    chk((pos != 0) ? 32'd1 : 32'd0, 1, "R5 count nonzero before index");
    pulse_idx();
    chk(pos, 0, "R5 index clears count");
    idx_match = 2'b10;  // needs A=0,B=1 (state 1)
    step(1'b1); step(1'b1); step(1'b1); // state 1, pos 3
    pulse_idx();
    chk(pos, 0, "R5 code 10 qualifies A0 B1");

    // R11
    load_val = 32'd777;
    idx_match = 2'b11;
    init_mode = 3'd0;
    goto_ph(2); base = pos;
    pulse_idx();
    chk(pos, base, "R11 mode 000 ignores index");
    init_mode = 3'd7;
    pulse_idx();
    chk(pos, base, "R11 mode 111 ignores index");

    // R7 first index after home
    init_mode = 3'd3; load_val = 32'd300;
    pulse_idx();
    chk(pos, base, "R7 unarmed index ignored");
    pulse_home();
    chk(pos, base, "R7 home alone no change");
    pulse_idx();
    chk(pos, 300, "R7 first index after home loads");
    step(1'b1); step(1'b0);
    load_val = 32'd400;
    pulse_idx();
    chk(pos, 300, "R7 disarmed after load");

    // R7 second index after home
    init_mode = 3'd4; load_val = 32'd900;
    pulse_home();
    pulse_idx();
    chk(pos, 300, "R7 mode 100 first index no load");
    pulse_idx();
    chk(pos, 900, "R7 mode 100 second index loads");
    pulse_idx();
    chk(pos, 900, "R7 mode 100 disarmed");

    // R8 compare clear
    cmp_val = 32'd903; init_mode = 3'd5;
    step(1'b1); step(1'b1);
    chk(pos, 902, "R8 below compare counts");
    step(1'b1);
    chk(pos, 0, "R8 cleared after reaching compare");

    // R9 modulo between 10 and 13
    init_mode = 3'd2; load_val = 32'd10; idx_match = 2'b11;
    goto_ph(2);
    pulse_idx();
    chk(pos, 10, "R9 preload lower bound");
    cmp_val = 32'd13; init_mode = 3'd6;
    step(1'b1); chk(pos, 11, "R9 up 11");
    step(1'b1); chk(pos, 12, "R9 up 12");
    step(1'b1); chk(pos, 13, "R9 up 13");
    step(1'b1); chk(pos, 10, "R9 wrap up to lower");
    step(1'b0); chk(pos, 13, "R9 wrap down to upper");
    step(1'b0); chk(pos, 12, "R9 down 12");

    // R10 timer sweep
    cnt_mode = 2'b10;
    for (int d = 0; d < 8; d++) begin
      int ratio;
      ratio = (d == 7) ? 256 : (1 << d);
      div_sel = d[2:0];
      wait_n(ratio + 4);
      base = pos;
      wait_n(ratio * 3);
      set_ph(ph + 1);      // phases ignored
      idx = 1'b1;          // index ignored
      wait_n(ratio * 5);
      idx = 1'b0;
      chk(pos - base, 8, $sformatf("R10 div_sel=%0d eight ticks", d));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule